// File: doc/BRIEF.md
# Two-Level Vector Register Mapper

This block renames vector registers in two hops for a vector core whose maximum vector length (MVL) can be changed at run time. At rename time every architectural vector destination receives a virtual vector register (VVR) from a pool of 64, and the sources of the same instruction are looked up in an architectural map table. A VVR goes back to the pool when the instruction that overwrote its architectural register commits.

At issue time each VVR that an instruction needs is bound to a slot of the physical vector register file. The file holds 8 KB of 64-bit elements, so the slot count falls from 64 to 8 as the MVL grows from 16 to 128 elements. When a requested VVR is not resident and no slot is free, the least recently issued unlocked resident VVR is evicted: the block requests a spill of the victim to a memory-backed register area, then a fill of the requested VVR into the freed slot, and only then reports the VVR ready. The data movement itself lives outside this block; it sees only request/acknowledge handshakes.

Top module: `vreg_two_level_map`

## Requirements
- R1: When `ren_valid` is high and at least one VVR is free, `ren_grant` is high in the same cycle and `ren_dst_vvr` is the lowest-numbered free VVR; that VVR becomes the new mapping of `ren_dst_arch`.
- R2: During a rename, `ren_old_valid`/`ren_old_vvr` and the source outputs report the mappings held before the same-cycle destination update; an architectural register never written since reset reads as not valid.
- R3: With all 64 VVRs allocated, `ren_grant` stays low.
- R4: A release (`rel_valid`) always takes effect; a rename arriving in the same cycle against an empty pool is refused, and the released VVR is granted from the next cycle on.
- R5: `mvl_active` resets to code 0. Codes 0, 1, 2, 3 mean MVL 16, 32, 64, 128 with 64, 32, 16, 8 physical slots. A `cfg_mvl_we` write takes effect on the next cycle only when no VVR is allocated; otherwise it is ignored.
- R6: An issue request (`iss_valid`) for a resident VVR gets `iss_ready` in the same cycle with that VVR's slot on `iss_slot`.
- R7: An issue request for a non-resident VVR with a free slot raises `fill_req` for the lowest free slot below the slot count, with no spill; `iss_ready` rises in the cycle after the cycle in which `fill_ack` is seen.
- R8: With no free slot, the victim is the resident VVR with zero lock count that was issued least recently (lowest VVR number on a tie); `spill_req` carries its number and slot, and after `spill_ack` the requested VVR is filled into that same slot.
- R9: An issue handshake with `iss_lock` high adds one to that VVR's lock count and `done_valid` removes one; a locked VVR is never a victim, and if every resident VVR is locked the request waits with neither spill nor fill raised.
- R10: At MVL code 0 no spill is ever requested, since all 64 VVRs fit.
- R11: Releasing a resident VVR frees its slot at once, so the next miss fills that slot with no spill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mvl_we | input | 1 | Write strobe for the MVL code |
| cfg_mvl_code | input | 2 | Requested MVL code (0..3 = 16..128) |
| mvl_active | output | 2 | MVL code in force |
| ren_valid | input | 1 | Rename request |
| ren_dst_arch | input | 5 | Architectural destination |
| ren_src1_arch | input | 5 | Architectural source 1 |
| ren_src2_arch | input | 5 | Architectural source 2 |
| ren_grant | output | 1 | Rename accepted this cycle |
| ren_dst_vvr | output | 6 | VVR given to the destination |
| ren_old_valid | output | 1 | Destination had a previous mapping |
| ren_old_vvr | output | 6 | Previous VVR of the destination |
| ren_src1_valid | output | 1 | Source 1 is mapped |
| ren_src1_vvr | output | 6 | VVR of source 1 |
| ren_src2_valid | output | 1 | Source 2 is mapped |
| ren_src2_vvr | output | 6 | VVR of source 2 |
| rel_valid | input | 1 | Commit-time release strobe |
| rel_vvr | input | 6 | VVR returned to the pool |
| iss_valid | input | 1 | Issue request, held until ready |
| iss_vvr | input | 6 | VVR needed by the instruction |
| iss_lock | input | 1 | Lock the VVR until completion |
| iss_ready | output | 1 | VVR resident, handshake done |
| iss_slot | output | 6 | Physical slot of the VVR |
| done_valid | input | 1 | Instruction completion, unlocks one |
| done_vvr | input | 6 | VVR to unlock |
| spill_req | output | 1 | Spill request |
| spill_vvr | output | 6 | VVR to spill |
| spill_slot | output | 6 | Slot to spill from |
| spill_ack | input | 1 | Spill done |
| fill_req | output | 1 | Fill request |
| fill_vvr | output | 6 | VVR to fill |
| fill_slot | output | 6 | Slot to fill into |
| fill_ack | input | 1 | Fill done |

## Verification
A wrong free bitmap shows at once on the rename port as a repeated or skipped `ren_dst_vvr`, or as a grant after the pool is full. A wrong resident or slot table shows on the next issue of the affected VVR, either as a ready with a wrong `iss_slot` or as a fill for a VVR that should already be present. Wrong recency stamps or lock counts stay hidden until the slots run out, and then appear as the wrong `spill_vvr` on the first eviction, which is why the bench fills every slot and then forces misses at several vector lengths.

// File: rtl/vmap_pkg.sv
// Shared types and helpers for the two-level vector register mapper.
// Assumes a 2-bit MVL code where each step doubles the vector length.
package vmap_pkg;

    // State of the serial slot-binding engine.
    typedef enum logic [1:0] {
        MAP_IDLE  = 2'd0,
        MAP_SPILL = 2'd1,
        MAP_FILL  = 2'd2
    } map_state_e;

    // Number of physical slots available at a given MVL code.
    function automatic int unsigned slots_for_code(input int unsigned max_slots,
                                                   input logic [1:0]  code);
        return max_slots >> code;
    endfunction

endpackage

// File: rtl/vmap_free_list.sv
// Pool of virtual vector registers kept as a bitmap.
// Hands out the lowest-numbered free entry; a release written in the same
// cycle is always applied and, being written last, wins on any index clash.
// Assumes the caller never releases an entry that is already free.
module vmap_free_list #(
    parameter int NUM_VVR = 64,
    localparam int VW = $clog2(NUM_VVR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    output logic          alloc_grant,
    output logic [VW-1:0] alloc_idx,
    input  logic          rel_valid,
    input  logic [VW-1:0] rel_idx,
    output logic          all_free
);

    logic [NUM_VVR-1:0] free_q;
    logic               any_free;

    // Priority pick of the lowest free entry.
    always_comb begin
        any_free  = 1'b0;
        alloc_idx = '0;
        for (int i = NUM_VVR - 1; i >= 0; i--) begin
            if (free_q[i]) begin
                any_free  = 1'b1;
                alloc_idx = VW'(i);
            end
        end
    end

    assign alloc_grant = alloc_req && any_free;
    assign all_free    = &free_q;

    // Bitmap update: allocation clears, release sets (release last = priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '1;
        end else begin
            if (alloc_grant) free_q[alloc_idx] <= 1'b0;
            if (rel_valid)   free_q[rel_idx]   <= 1'b1;
        end
    end

    // R1: a granted entry has left the pool on the next cycle
    a_r1_grant_leaves_pool: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_grant && !(rel_valid && rel_idx == alloc_idx)) |=> !free_q[$past(alloc_idx)]);

    // R3: an empty pool never grants
    a_r3_full_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q == '0) |-> !alloc_grant);

    // R4: a release is always back in the pool on the next cycle
    a_r4_release_returns: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> free_q[$past(rel_idx)]);

endmodule

// File: rtl/vmap_arch_table.sv
// Architectural-to-VVR map table with one write port and NRD read ports.
// Reads are combinational and see the contents before a same-cycle write,
// which gives the old mapping of the destination and correct sources.
module vmap_arch_table #(
    parameter int NUM_ARCH = 32,
    parameter int NUM_VVR  = 64,
    parameter int NRD      = 3,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int VW = $clog2(NUM_VVR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_arch,
    input  logic [VW-1:0]          wr_vvr,
    input  logic [NRD-1:0][AW-1:0] rd_arch,
    output logic [NRD-1:0]         rd_valid,
    output logic [NRD-1:0][VW-1:0] rd_vvr
);

    logic [NUM_ARCH-1:0] map_v_q;
    logic [VW-1:0]       map_q [NUM_ARCH];

    // Table update on a granted rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v_q <= '0;
            for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= '0;
        end else if (wr_en) begin
            map_v_q[wr_arch] <= 1'b1;
            map_q[wr_arch]   <= wr_vvr;
        end
    end

    // One combinational lookup per read port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_valid[g] = map_v_q[rd_arch[g]];
        assign rd_vvr[g]   = map_q[rd_arch[g]];
    end

    // R2: a written entry reads back as valid with the written VVR
    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_v_q[$past(wr_arch)] && map_q[$past(wr_arch)] == $past(wr_vvr)));

endmodule

// File: rtl/vmap_phys_mapper.sv
// Second mapping level: binds VVRs to physical register file slots.
// Keeps per-VVR resident bit, slot, lock count and last-issue stamp.
// A miss takes a free slot if one exists below the active slot count,
// otherwise evicts the least recently issued unlocked resident VVR through
// a spill handshake, then fills the requested VVR into the slot.
// Assumes iss_valid is held until iss_ready, that only allocated VVRs are
// issued, and that a VVR is not released while it is being spilled or filled.
module vmap_phys_mapper
    import vmap_pkg::*;
#(
    parameter int NUM_VVR  = 64,
    parameter int SLOT_MAX = 64,
    parameter int LOCK_W   = 3,
    parameter int STAMP_W  = 16,
    localparam int VW = $clog2(NUM_VVR),
    localparam int SW = $clog2(SLOT_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mvl_code,
    input  logic          iss_valid,
    input  logic [VW-1:0] iss_vvr,
    input  logic          iss_lock,
    output logic          iss_ready,
    output logic [SW-1:0] iss_slot,
    input  logic          done_valid,
    input  logic [VW-1:0] done_vvr,
    input  logic          rel_valid,
    input  logic [VW-1:0] rel_vvr,
    output logic          spill_req,
    output logic [VW-1:0] spill_vvr,
    output logic [SW-1:0] spill_slot,
    input  logic          spill_ack,
    output logic          fill_req,
    output logic [VW-1:0] fill_vvr,
    output logic [SW-1:0] fill_slot,
    input  logic          fill_ack
);

    logic [NUM_VVR-1:0]  res_q;
    logic [SW-1:0]       slot_q  [NUM_VVR];
    logic [LOCK_W-1:0]   lock_q  [NUM_VVR];
    logic [STAMP_W-1:0]  stamp_q [NUM_VVR];
    logic [SLOT_MAX-1:0] used_q;
    logic [STAMP_W-1:0]  use_ctr_q;
    map_state_e          st_q;
    logic [VW-1:0]       req_vvr_q;
    logic [VW-1:0]       vic_vvr_q;
    logic [SW-1:0]       tgt_slot_q;

    logic [SW:0]         nslots;
    logic                free_found;
    logic [SW-1:0]       free_slot;
    logic                vic_found;
    logic [VW-1:0]       vic_idx;
    logic [STAMP_W-1:0]  vic_stamp;

    assign nslots = (SW+1)'(slots_for_code(SLOT_MAX, mvl_code));

    // Lowest unused slot that lies inside the active slot count.
    always_comb begin
        free_found = 1'b0;
        free_slot  = '0;
        for (int i = SLOT_MAX - 1; i >= 0; i--) begin
            if (!used_q[i] && ((SW+1)'(i) < nslots)) begin
                free_found = 1'b1;
                free_slot  = SW'(i);
            end
        end
    end

    // Oldest-stamp unlocked resident VVR; lower number wins a tie.
    always_comb begin
        vic_found = 1'b0;
        vic_idx   = '0;
        vic_stamp = '1;
        for (int v = 0; v < NUM_VVR; v++) begin
            if (res_q[v] && lock_q[v] == '0 && (!vic_found || stamp_q[v] < vic_stamp)) begin
                vic_found = 1'b1;
                vic_idx   = VW'(v);
                vic_stamp = stamp_q[v];
            end
        end
    end

    // Handshake outputs.
    assign iss_ready  = (st_q == MAP_IDLE) && iss_valid && res_q[iss_vvr];
    assign iss_slot   = slot_q[iss_vvr];
    assign spill_req  = (st_q == MAP_SPILL);
    assign spill_vvr  = vic_vvr_q;
    assign spill_slot = tgt_slot_q;
    assign fill_req   = (st_q == MAP_FILL);
    assign fill_vvr   = req_vvr_q;
    assign fill_slot  = tgt_slot_q;

    // Miss engine, recency stamps and residency bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= MAP_IDLE;
            res_q      <= '0;
            used_q     <= '0;
            use_ctr_q  <= '0;
            req_vvr_q  <= '0;
            vic_vvr_q  <= '0;
            tgt_slot_q <= '0;
            for (int v = 0; v < NUM_VVR; v++) begin
                slot_q[v]  <= '0;
                stamp_q[v] <= '0;
            end
        end else begin
            case (st_q)
                MAP_IDLE: begin
                    if (iss_valid && !res_q[iss_vvr]) begin
                        req_vvr_q <= iss_vvr;
                        if (free_found) begin
                            tgt_slot_q        <= free_slot;
                            used_q[free_slot] <= 1'b1;
                            st_q              <= MAP_FILL;
                        end else if (vic_found) begin
                            vic_vvr_q  <= vic_idx;
                            tgt_slot_q <= slot_q[vic_idx];
                            st_q       <= MAP_SPILL;
                        end
                    end
                end
                MAP_SPILL: begin
                    if (spill_ack) begin
                        res_q[vic_vvr_q] <= 1'b0;
                        st_q             <= MAP_FILL;
                    end
                end
                MAP_FILL: begin
                    if (fill_ack) begin
                        res_q[req_vvr_q]  <= 1'b1;
                        slot_q[req_vvr_q] <= tgt_slot_q;
                        st_q              <= MAP_IDLE;
                    end
                end
                default: st_q <= MAP_IDLE;
            endcase
            if (iss_ready) begin
                stamp_q[iss_vvr] <= use_ctr_q;
                use_ctr_q        <= use_ctr_q + STAMP_W'(1);
            end
            if (rel_valid && res_q[rel_vvr]) begin
                res_q[rel_vvr]          <= 1'b0;
                used_q[slot_q[rel_vvr]] <= 1'b0;
            end
        end
    end

    // Lock counters: one up per locking issue, one down per completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VVR; v++) lock_q[v] <= '0;
        end else begin
            for (int v = 0; v < NUM_VVR; v++) begin
                if ((iss_ready && iss_lock && iss_vvr == VW'(v)) && !(done_valid && done_vvr == VW'(v)))
                    lock_q[v] <= lock_q[v] + LOCK_W'(1);
                else if (!(iss_ready && iss_lock && iss_vvr == VW'(v)) && (done_valid && done_vvr == VW'(v)))
                    lock_q[v] <= lock_q[v] - LOCK_W'(1);
            end
        end
    end

    // R6: ready is only given for a resident VVR
    a_r6_ready_resident: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |-> res_q[iss_vvr]);

    // R7: an acknowledged fill leaves the VVR resident in the target slot
    a_r7_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_ack) |=> (res_q[$past(req_vvr_q)] && slot_q[$past(req_vvr_q)] == $past(tgt_slot_q)));

    // R8: the spilled VVR is resident and owns the slot being spilled
    a_r8_victim_owns_slot: assert property (@(posedge clk) disable iff (!rst_n)
        spill_req |-> (res_q[spill_vvr] && slot_q[spill_vvr] == spill_slot));

    // R9: a locked VVR is never spilled
    a_r9_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        spill_req |-> (lock_q[spill_vvr] == '0));

    // R9: completion never unlocks a VVR with no lock outstanding
    a_r9_lock_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (lock_q[done_vvr] != '0));

    // R10: baseline length never spills
    a_r10_baseline_no_spill: assert property (@(posedge clk) disable iff (!rst_n)
        (mvl_code == 2'd0) |-> !spill_req);

    // R5: residents never exceed the active slot count
    a_r5_resident_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(res_q) <= nslots);

endmodule

// File: rtl/vreg_two_level_map.sv
// Top of the two-level vector register mapper.
// Stage one renames architectural vector registers to VVRs from a free pool;
// stage two binds VVRs to physical slots whose count depends on the MVL code.
// Assumes one rename and one issue request per cycle and that the MVL is
// reconfigured only while every VVR is free.
module vreg_two_level_map #(
    parameter int NUM_ARCH   = 32,
    parameter int NUM_VVR    = 64,
    parameter int RF_BYTES   = 8192,
    parameter int ELEM_BYTES = 8,
    parameter int MVL_MIN    = 16,
    parameter int LOCK_W     = 3,
    parameter int STAMP_W    = 16,
    localparam int SLOT_MAX = RF_BYTES / (MVL_MIN * ELEM_BYTES),
    localparam int AW = $clog2(NUM_ARCH),
    localparam int VW = $clog2(NUM_VVR),
    localparam int SW = $clog2(SLOT_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_mvl_we,
    input  logic [1:0]    cfg_mvl_code,
    output logic [1:0]    mvl_active,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_dst_arch,
    input  logic [AW-1:0] ren_src1_arch,
    input  logic [AW-1:0] ren_src2_arch,
    output logic          ren_grant,
    output logic [VW-1:0] ren_dst_vvr,
    output logic          ren_old_valid,
    output logic [VW-1:0] ren_old_vvr,
    output logic          ren_src1_valid,
    output logic [VW-1:0] ren_src1_vvr,
    output logic          ren_src2_valid,
    output logic [VW-1:0] ren_src2_vvr,
    input  logic          rel_valid,
    input  logic [VW-1:0] rel_vvr,
    input  logic          iss_valid,
    input  logic [VW-1:0] iss_vvr,
    input  logic          iss_lock,
    output logic          iss_ready,
    output logic [SW-1:0] iss_slot,
    input  logic          done_valid,
    input  logic [VW-1:0] done_vvr,
    output logic          spill_req,
    output logic [VW-1:0] spill_vvr,
    output logic [SW-1:0] spill_slot,
    input  logic          spill_ack,
    output logic          fill_req,
    output logic [VW-1:0] fill_vvr,
    output logic [SW-1:0] fill_slot,
    input  logic          fill_ack
);

    logic [1:0]          mvl_q;
    logic                all_free;
    logic [2:0][AW-1:0]  rd_arch;
    logic [2:0]          rd_valid;
    logic [2:0][VW-1:0]  rd_vvr;

    // MVL register: a write lands only while no VVR is allocated.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mvl_q <= 2'd0;
        else if (cfg_mvl_we && all_free)  mvl_q <= cfg_mvl_code;
    end

    assign mvl_active = mvl_q;

    vmap_free_list #(.NUM_VVR(NUM_VVR)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (ren_valid),
        .alloc_grant(ren_grant),
        .alloc_idx  (ren_dst_vvr),
        .rel_valid  (rel_valid),
        .rel_idx    (rel_vvr),
        .all_free   (all_free)
    );

    assign rd_arch[0] = ren_dst_arch;
    assign rd_arch[1] = ren_src1_arch;
    assign rd_arch[2] = ren_src2_arch;

    vmap_arch_table #(.NUM_ARCH(NUM_ARCH), .NUM_VVR(NUM_VVR), .NRD(3)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ren_grant),
        .wr_arch (ren_dst_arch),
        .wr_vvr  (ren_dst_vvr),
        .rd_arch (rd_arch),
        .rd_valid(rd_valid),
        .rd_vvr  (rd_vvr)
    );

    assign ren_old_valid  = rd_valid[0];
    assign ren_old_vvr    = rd_vvr[0];
    assign ren_src1_valid = rd_valid[1];
    assign ren_src1_vvr   = rd_vvr[1];
    assign ren_src2_valid = rd_valid[2];
    assign ren_src2_vvr   = rd_vvr[2];

    vmap_phys_mapper #(
        .NUM_VVR (NUM_VVR),
        .SLOT_MAX(SLOT_MAX),
        .LOCK_W  (LOCK_W),
        .STAMP_W (STAMP_W)
    ) u_phys (
        .clk       (clk),
        .rst_n     (rst_n),
        .mvl_code  (mvl_q),
        .iss_valid (iss_valid),
        .iss_vvr   (iss_vvr),
        .iss_lock  (iss_lock),
        .iss_ready (iss_ready),
        .iss_slot  (iss_slot),
        .done_valid(done_valid),
        .done_vvr  (done_vvr),
        .rel_valid (rel_valid),
        .rel_vvr   (rel_vvr),
        .spill_req (spill_req),
        .spill_vvr (spill_vvr),
        .spill_slot(spill_slot),
        .spill_ack (spill_ack),
        .fill_req  (fill_req),
        .fill_vvr  (fill_vvr),
        .fill_slot (fill_slot),
        .fill_ack  (fill_ack)
    );

    // R5: the MVL code cannot change while any VVR is allocated
    a_r5_mvl_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !all_free |=> $stable(mvl_q));

endmodule

// File: tb/vreg_two_level_map_bench.sv
// Directed bench for the two-level vector register mapper.
module vreg_two_level_map_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_mvl_we;
    logic [1:0] cfg_mvl_code;
    logic [1:0] mvl_active;
    logic       ren_valid;
    logic [4:0] ren_dst_arch, ren_src1_arch, ren_src2_arch;
    logic       ren_grant;
    logic [5:0] ren_dst_vvr;
    logic       ren_old_valid;
    logic [5:0] ren_old_vvr;
    logic       ren_src1_valid;
    logic [5:0] ren_src1_vvr;
    logic       ren_src2_valid;
    logic [5:0] ren_src2_vvr;
    logic       rel_valid;
    logic [5:0] rel_vvr;
    logic       iss_valid;
    logic [5:0] iss_vvr;
    logic       iss_lock;
    logic       iss_ready;
    logic [5:0] iss_slot;
    logic       done_valid;
    logic [5:0] done_vvr;
    logic       spill_req;
    logic [5:0] spill_vvr, spill_slot;
    logic       spill_ack;
    logic       fill_req;
    logic [5:0] fill_vvr, fill_slot;
    logic       fill_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    // captured rename results
    logic r_grant, r_old_v, r_s1_v, r_s2_v;
    int   r_dst, r_old, r_s1, r_s2;
    // captured issue results
    logic i_ok, i_sp, i_fl;
    int   i_slot, i_sp_vvr, i_sp_slot, i_fl_vvr, i_fl_slot, i_fl_cyc, i_rdy_cyc;

    always #2 clk = ~clk;

    vreg_two_level_map u_vreg_two_level_map (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_mvl_we = 0; cfg_mvl_code = 0; ren_valid = 0;
        ren_dst_arch = 0; ren_src1_arch = 0; ren_src2_arch = 0;
        rel_valid = 0; rel_vvr = 0; iss_valid = 0; iss_vvr = 0; iss_lock = 0;
        done_valid = 0; done_vvr = 0; spill_ack = 0; fill_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_rename(input int dst, input int s1, input int s2);
        @(negedge clk);
        ren_valid = 1; ren_dst_arch = 5'(dst); ren_src1_arch = 5'(s1); ren_src2_arch = 5'(s2);
        #1;
        r_grant = ren_grant; r_dst = ren_dst_vvr; r_old_v = ren_old_valid; r_old = ren_old_vvr;
        r_s1_v = ren_src1_valid; r_s1 = ren_src1_vvr; r_s2_v = ren_src2_valid; r_s2 = ren_src2_vvr;
        @(posedge clk); #1;
        ren_valid = 0;
    endtask

    task automatic do_release(input int v);
        @(negedge clk);
        rel_valid = 1; rel_vvr = 6'(v);
        @(posedge clk); #1;
        rel_valid = 0;
    endtask

    task automatic do_cfg(input int code);
        @(negedge clk);
        cfg_mvl_we = 1; cfg_mvl_code = 2'(code);
        @(posedge clk); #1;
        cfg_mvl_we = 0;
    endtask

    task automatic do_done(input int v);
        @(negedge clk);
        done_valid = 1; done_vvr = 6'(v);
        @(posedge clk); #1;
        done_valid = 0;
    endtask

    // Watches an already raised issue request until ready, acking spill/fill.
    task automatic run_issue();
        i_ok = 0; i_sp = 0; i_fl = 0; i_slot = -1; i_sp_vvr = -1; i_sp_slot = -1;
        i_fl_vvr = -1; i_fl_slot = -1; i_fl_cyc = -1; i_rdy_cyc = -1;
        for (int c = 0; c < 40; c++) begin
            #1;
            if (iss_ready) begin
                i_ok = 1; i_slot = iss_slot; i_rdy_cyc = c;
                break;
            end
            if (spill_req) begin
                i_sp = 1; i_sp_vvr = spill_vvr; i_sp_slot = spill_slot; spill_ack = 1;
            end
            if (fill_req) begin
                i_fl = 1; i_fl_vvr = fill_vvr; i_fl_slot = fill_slot; fill_ack = 1; i_fl_cyc = c;
            end
            @(negedge clk);
            spill_ack = 0; fill_ack = 0;
        end
        @(posedge clk); #1;
        iss_valid = 0; iss_lock = 0;
    endtask

    task automatic do_issue(input int v, input bit lk);
        @(negedge clk);
        iss_valid = 1; iss_vvr = 6'(v); iss_lock = lk;
        run_issue();
    endtask

    // Issue a VVR that must miss into a free slot.
    task automatic issue_fill(input string req, input int v, input int slot, input bit lk);
        do_issue(v, lk);
        chk(req, "ready seen", i_ok, 1);
        chk(req, "no spill", i_sp, 0);
        chk(req, "fill slot", i_fl_slot, slot);
        chk(req, "ready one cycle after fill ack", i_rdy_cyc, i_fl_cyc + 1);
        chk(req, "iss_slot", i_slot, slot);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R5", "mvl_active after reset", mvl_active, 0);
        chk("R6", "iss_ready idle", iss_ready, 0);
        chk("R7", "fill_req idle", fill_req, 0);
        chk("R8", "spill_req idle", spill_req, 0);
        chk("R1", "grant idle", ren_grant, 0);
    endtask

    task automatic t_rename();
        do_reset();
        do_rename(3, 3, 7);
        chk("R1", "first grant", r_grant, 1);
        chk("R1", "first vvr", r_dst, 0);
        chk("R2", "unwritten old not valid", r_old_v, 0);
        chk("R2", "unwritten src not valid", r_s1_v, 0);
        do_rename(7, 3, 3);
        chk("R1", "second vvr", r_dst, 1);
        chk("R2", "src1 valid", r_s1_v, 1);
        chk("R2", "src1 vvr", r_s1, 0);
        do_rename(3, 3, 7);
        chk("R1", "third vvr", r_dst, 2);
        chk("R2", "old valid", r_old_v, 1);
        chk("R2", "old vvr", r_old, 0);
        chk("R2", "src reads pre-update", r_s1, 0);
        chk("R2", "src2 vvr", r_s2, 1);
    endtask

    task automatic t_full_and_mvl();
        int bad_ord;
        do_reset();
        bad_ord = 0;
        for (int i = 0; i < 64; i++) begin
            do_rename(i % 32, 0, 0);
            if (!r_grant || r_dst != i) bad_ord++;
        end
        chk("R1", "64 grants in ascending order", bad_ord, 0);
        do_rename(1, 0, 0);
        chk("R3", "grant when pool empty", r_grant, 0);
        // release and rename in the same cycle
        @(negedge clk);
        ren_valid = 1; ren_dst_arch = 5'd4; rel_valid = 1; rel_vvr = 6'd5;
        #1;
        chk("R4", "same-cycle rename refused", ren_grant, 0);
        @(posedge clk); #1;
        rel_valid = 0;
        @(negedge clk); #1;
        chk("R4", "released vvr granted next cycle", ren_grant, 1);
        chk("R4", "released vvr number", ren_dst_vvr, 5);
        @(posedge clk); #1;
        ren_valid = 0;
        do_rename(2, 0, 0);
        chk("R3", "pool empty again", r_grant, 0);
        do_cfg(3);
        chk("R5", "mvl write ignored while busy", mvl_active, 0);
        for (int i = 0; i < 64; i++) do_release(i);
        do_cfg(3);
        chk("R5", "mvl write accepted when idle", mvl_active, 3);
    endtask

    task automatic t_lru();
        do_reset();
        do_cfg(3);
        for (int i = 0; i < 10; i++) do_rename(i % 32, 0, 0);
        for (int i = 0; i < 8; i++) issue_fill("R7", i, i, 0);
        do_issue(3, 0);
        chk("R6", "resident ready same cycle", i_rdy_cyc, 0);
        chk("R6", "resident slot", i_slot, 3);
        chk("R6", "resident no fill", i_fl, 0);
        do_issue(8, 0);
        chk("R8", "spill raised", i_sp, 1);
        chk("R8", "lru victim", i_sp_vvr, 0);
        chk("R8", "victim slot", i_sp_slot, 0);
        chk("R8", "fill into victim slot", i_fl_slot, 0);
        chk("R8", "fill vvr", i_fl_vvr, 8);
        chk("R8", "ready slot", i_slot, 0);
        do_issue(0, 0);
        chk("R8", "second victim", i_sp_vvr, 1);
        chk("R8", "second slot", i_fl_slot, 1);
    endtask

    task automatic t_lock();
        int stray;
        do_reset();
        do_cfg(3);
        for (int i = 0; i < 9; i++) do_rename(i, 0, 0);
        for (int i = 0; i < 8; i++) issue_fill("R9", i, i, 1);
        for (int i = 1; i < 8; i++) do_done(i);
        do_issue(8, 0);
        chk("R9", "locked lru skipped", i_sp_vvr, 1);
        chk("R9", "slot of unlocked victim", i_fl_slot, 1);
        for (int i = 2; i < 9; i++) do_issue(i, 1);
        @(negedge clk);
        iss_valid = 1; iss_vvr = 6'd1; iss_lock = 0;
        stray = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk); #1;
            if (spill_req || fill_req || iss_ready) stray++;
        end
        chk("R9", "all locked: request waits", stray, 0);
        do_done(5);
        run_issue();
        chk("R9", "unlocked vvr becomes victim", i_sp_vvr, 5);
        chk("R9", "fill into freed slot", i_fl_slot, 5);
        chk("R9", "ready after unlock", i_ok, 1);
    endtask

    task automatic t_release_resident();
        do_reset();
        do_cfg(3);
        for (int i = 0; i < 9; i++) do_rename(i, 0, 0);
        for (int i = 0; i < 8; i++) issue_fill("R11", i, i, 0);
        do_release(3);
        issue_fill("R11", 8, 3, 0);
    endtask

    task automatic t_mvl32();
        do_reset();
        do_cfg(1);
        chk("R5", "mvl code 1 active", mvl_active, 1);
        for (int i = 0; i < 33; i++) do_rename(i % 32, 0, 0);
        for (int i = 0; i < 32; i++) issue_fill("R5", i, i, 0);
        do_issue(32, 0);
        chk("R5", "33rd vvr spills at 32 slots", i_sp, 1);
        chk("R5", "victim at 32 slots", i_sp_vvr, 0);
    endtask

    task automatic t_baseline();
        int spills;
        do_reset();
        for (int i = 0; i < 64; i++) do_rename(i % 32, 0, 0);
        spills = 0;
        for (int i = 0; i < 64; i++) begin
            do_issue(i, 0);
            if (i_sp) spills++;
            if (i_fl_slot != i) spills++;
        end
        chk("R10", "64 vvrs resident without spill", spills, 0);
        do_issue(0, 0);
        chk("R10", "vvr 0 still resident", i_rdy_cyc, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_rename();
        t_full_and_mvl();
        t_lru();
        t_lock();
        t_release_resident();
        t_mvl32();
        t_baseline();
        finish_run();
    end

endmodule